// File: doc/BRIEF.md
# Multiplexed External SRAM Bus Controller

This block lets an 8-bit core reach an SRAM that sits outside the chip. The SRAM shares one 8-bit pin group for both the low address byte and the data. A second 8-bit pin group carries the high address byte. A small control register turns the bus function on and can add one wait cycle to every access. While the bus function is on, the controller owns both pin groups. It ignores the values and direction settings that the general-purpose port logic presents. While the bus function is off, that port logic passes straight through to the pins.

The core issues a request with an address, a direction flag and, for a write, a data byte. The controller serves only addresses above a parameterised internal-memory top. Any other address is left to the on-chip memory, and the pins do not move. An external access begins with a one-cycle address phase. In that phase the low address is placed on the shared pins and an active-high latch strobe pulses, so the SRAM can capture the low address. The phase that follows uses either an active-low write strobe with the write data driven, or an active-low read strobe with the shared pins released. The controller holds the core in a stall while the access runs. It then pulses a completion signal together with the captured read byte.

Top module: `xmem_bus_ctrl`

## Requirements
- R1: The control register resets to 0x00. Bit 7 is the bus enable and bit 6 is the wait enable. Both can be written with `cfgWe`, and bits 5..0 always read back as zero.
- R2: With bus enable clear, `padLoOut`/`padLoOe` equal `gpLoOut`/`gpLoDir` and `padHiOut`/`padHiOe` equal `gpHiOut`/`gpHiDir`. Also `ale`=0, `rdN`=1 and `wrN`=1, and a request starts no access.
- R3: With bus enable set and no access running, `padHiOe` is all ones and `padLoOe` is all zeros, whatever the general-purpose direction inputs hold, and no strobe is active.
- R4: A request whose address is at or below INT_TOP (default 0x0FFF) starts no external access. `stall`, `done` and `ale` stay low, and `rdN` and `wrN` stay high. INT_TOP+1 is the lowest external address.
- R5: With wait enable clear, an access occupies exactly three cycles: one address cycle followed by two strobe cycles.
- R6: With wait enable set, an access occupies exactly four cycles: one address cycle followed by three strobe cycles.
- R7: In the address cycle, `ale`=1, `padLoOut` holds the address bits 7..0, `padLoOe`=0xFF, and both strobes are high. `padHiOut` holds the address bits 15..8 in every cycle of the access.
- R8: In a write, `wrN` is low in every strobe cycle, `rdN` stays high, and `padLoOut` drives the write byte with `padLoOe`=0xFF. The addressed SRAM location then holds that byte.
- R9: In a read, `rdN` is low in every strobe cycle, `wrN` stays high, and `padLoOe`=0x00. The byte on `padLoIn` in the last strobe cycle appears on `rdData` in the cycle after that.
- R10: `stall` is high from the cycle in which an external request is accepted through the last strobe cycle. `done` is a single-cycle pulse in the following cycle, and `stall` is then low.

Top module port list order follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWe | input | 1 | Control register write enable |
| cfgWdata | input | 8 | Control register write value |
| cfgRdata | output | 8 | Control register read value |
| reqValid | input | 1 | Core access request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 16 | Request address |
| reqWdata | input | 8 | Write byte |
| stall | output | 1 | Holds the core during an external access |
| done | output | 1 | Completion pulse |
| rdData | output | 8 | Captured read byte |
| gpLoOut | input | 8 | Port logic output value, shared pin group |
| gpLoDir | input | 8 | Port logic direction, shared pin group |
| gpHiOut | input | 8 | Port logic output value, high pin group |
| gpHiDir | input | 8 | Port logic direction, high pin group |
| padLoIn | input | 8 | Shared pin group input value |
| padLoOut | output | 8 | Shared pin group output value |
| padLoOe | output | 8 | Shared pin group output enables |
| padHiOut | output | 8 | High pin group output value |
| padHiOe | output | 8 | High pin group output enables |
| ale | output | 1 | Address latch strobe, active high |
| rdN | output | 1 | Read strobe, active low |
| wrN | output | 1 | Write strobe, active low |

## Verification
A state machine stuck in a strobe state would keep `stall` high and hold a strobe low. The bench would see this one cycle past the expected end, because it tests the strobe levels and `done` in exact cycles. If the wait-cycle path or the address latch were wrong, the strobe window would be one cycle short or long. The same fault would show up as a different byte stored in the modelled SRAM, or as a mismatch in the next read of that location. A pin-ownership fault (the override being wrong) shows in the same cycle as a mismatch between the pad outputs and the general-purpose inputs or the fixed bus directions.

// File: rtl/xmem_pkg.sv
package xmem_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_STRB,
    ST_WAIT,
    ST_LAST
  } xmemState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // take request address/data
    logic aleOn;     // address phase
    logic rdOn;      // read strobe active
    logic wrOn;      // write strobe active
    logic loDrive;   // shared pins driven by bus
    logic rdSample;  // capture shared pins into rdData
  } xmemStrb_t;

endpackage

// File: rtl/xmem_ctrl.sv
module xmem_ctrl
  import xmem_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int INT_TOP = 'h0FFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              busEn,
  input  logic              waitEn,
  output xmemStrb_t         strb,
  output logic              busy,
  output logic              stall,
  output logic              done
);

  localparam logic [ADDR_W-1:0] TOP_L = ADDR_W'(INT_TOP);

  xmemState_t state, stateNxt;
  logic       opWrite;
  logic       waitLat;
  logic       isExt;
  logic       accept;
  logic       strbPhase;

  assign isExt  = reqAddr > TOP_L;
  assign accept = (state == ST_IDLE) && reqValid && busEn && isExt;

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE: if (accept) stateNxt = ST_ADDR;
      ST_ADDR: stateNxt = ST_STRB;
      ST_STRB: stateNxt = waitLat ? ST_WAIT : ST_LAST;
      ST_WAIT: stateNxt = ST_LAST;
      ST_LAST: stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      opWrite <= 1'b0;
      waitLat <= 1'b0;
      done    <= 1'b0;
    end else begin
      state <= stateNxt;
      done  <= (state == ST_LAST);
      if (accept) begin
        opWrite <= reqWrite;
        waitLat <= waitEn;
      end
    end
  end

  assign strbPhase = (state == ST_STRB) || (state == ST_WAIT) || (state == ST_LAST);

  always_comb begin
    strb.capture  = accept;
    strb.aleOn    = (state == ST_ADDR);
    strb.rdOn     = strbPhase && !opWrite;
    strb.wrOn     = strbPhase && opWrite;
    strb.loDrive  = (state == ST_ADDR) || (strbPhase && opWrite);
    strb.rdSample = (state == ST_LAST) && !opWrite;
  end

  assign busy  = (state != ST_IDLE);
  assign stall = busy || accept;

  // R7
  aleOneCycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.aleOn |=> !strb.aleOn);

  // R5
  strobeAfterAle_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.aleOn |=> (strb.rdOn || strb.wrOn));

  // R8
  rdWrExcl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.rdOn && strb.wrOn));

  // R10
  donePulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R4
  internalBypass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && reqValid && !isExt) |=> !busy);

endmodule

// File: rtl/xmem_dpath.sv
module xmem_dpath
  import xmem_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [DATA_W-1:0] cfgWdata,
  output logic [DATA_W-1:0] cfgRdata,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  xmemStrb_t         strb,
  input  logic              busy,
  output logic              busEn,
  output logic              waitEn,
  output logic [DATA_W-1:0] rdData,
  input  logic [DATA_W-1:0] gpLoOut,
  input  logic [DATA_W-1:0] gpLoDir,
  input  logic [HI_W-1:0]   gpHiOut,
  input  logic [HI_W-1:0]   gpHiDir,
  input  logic [DATA_W-1:0] padLoIn,
  output logic [DATA_W-1:0] padLoOut,
  output logic [DATA_W-1:0] padLoOe,
  output logic [HI_W-1:0]   padHiOut,
  output logic [HI_W-1:0]   padHiOe,
  output logic              ale,
  output logic              rdN,
  output logic              wrN
);

  localparam int HI_W = ADDR_W - DATA_W;
  localparam int EN_BIT = DATA_W - 1;
  localparam int WS_BIT = DATA_W - 2;

  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] wdataReg;
  logic              override;
  logic              cfgUnused;

  assign cfgUnused = ^cfgWdata[WS_BIT-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busEn    <= 1'b0;
      waitEn   <= 1'b0;
      addrReg  <= '0;
      wdataReg <= '0;
      rdData   <= '0;
    end else begin
      if (cfgWe) begin
        busEn  <= cfgWdata[EN_BIT];
        waitEn <= cfgWdata[WS_BIT];
      end
      if (strb.capture) begin
        addrReg  <= reqAddr;
        wdataReg <= reqWdata;
      end
      if (strb.rdSample) rdData <= padLoIn;
    end
  end

  assign cfgRdata = {busEn, waitEn, {(DATA_W-2){1'b0}}};

  // pins stay with the bus until a running access ends
  assign override = busEn || busy;

  for (genvar b = 0; b < DATA_W; b++) begin : g_loPin
    assign padLoOut[b] = override ? (strb.aleOn ? addrReg[b] : wdataReg[b]) : gpLoOut[b];
    assign padLoOe[b]  = override ? strb.loDrive : gpLoDir[b];
  end

  for (genvar h = 0; h < HI_W; h++) begin : g_hiPin
    assign padHiOut[h] = override ? addrReg[DATA_W+h] : gpHiOut[h];
    assign padHiOe[h]  = override ? 1'b1 : gpHiDir[h];
  end

  assign ale = strb.aleOn;
  assign rdN = !strb.rdOn;
  assign wrN = !strb.wrOn;

  // R9
  readRelease_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdN |-> (padLoOe == '0));

  // R8
  writeDrive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrN |-> (padLoOe == '1));

  // R3
  hiOwned_chk: assert property (@(posedge clk) disable iff (!rstN)
    busEn |-> (padHiOe == '1));

  // R7
  hiStable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ale && (!rdN || !wrN)) |-> $stable(padHiOut));

endmodule

// File: rtl/xmem_bus_ctrl.sv
module xmem_bus_ctrl
  import xmem_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int INT_TOP = 'h0FFF
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cfgWe,
  input  logic [DATA_W-1:0]        cfgWdata,
  output logic [DATA_W-1:0]        cfgRdata,
  input  logic                     reqValid,
  input  logic                     reqWrite,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic [DATA_W-1:0]        reqWdata,
  output logic                     stall,
  output logic                     done,
  output logic [DATA_W-1:0]        rdData,
  input  logic [DATA_W-1:0]        gpLoOut,
  input  logic [DATA_W-1:0]        gpLoDir,
  input  logic [ADDR_W-DATA_W-1:0] gpHiOut,
  input  logic [ADDR_W-DATA_W-1:0] gpHiDir,
  input  logic [DATA_W-1:0]        padLoIn,
  output logic [DATA_W-1:0]        padLoOut,
  output logic [DATA_W-1:0]        padLoOe,
  output logic [ADDR_W-DATA_W-1:0] padHiOut,
  output logic [ADDR_W-DATA_W-1:0] padHiOe,
  output logic                     ale,
  output logic                     rdN,
  output logic                     wrN
);

  xmemStrb_t strb;
  logic      busy;
  logic      busEn;
  logic      waitEn;

  xmem_ctrl #(.ADDR_W(ADDR_W), .INT_TOP(INT_TOP)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .busEn    (busEn),
    .waitEn   (waitEn),
    .strb     (strb),
    .busy     (busy),
    .stall    (stall),
    .done     (done)
  );

  xmem_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWe    (cfgWe),
    .cfgWdata (cfgWdata),
    .cfgRdata (cfgRdata),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .strb     (strb),
    .busy     (busy),
    .busEn    (busEn),
    .waitEn   (waitEn),
    .rdData   (rdData),
    .gpLoOut  (gpLoOut),
    .gpLoDir  (gpLoDir),
    .gpHiOut  (gpHiOut),
    .gpHiDir  (gpHiDir),
    .padLoIn  (padLoIn),
    .padLoOut (padLoOut),
    .padLoOe  (padLoOe),
    .padHiOut (padHiOut),
    .padHiOe  (padHiOe),
    .ale      (ale),
    .rdN      (rdN),
    .wrN      (wrN)
  );

endmodule

// File: tb/sim_xmem_bus_ctrl.sv
`timescale 1ns/1ps
module sim_xmem_bus_ctrl;

  localparam int TOP = 'h0FFF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [7:0]  cfgWdata = '0;
  logic [7:0]  cfgRdata;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic        stall, done;
  logic [7:0]  rdData;
  logic [7:0]  gpLoOut = '0, gpLoDir = '0, gpHiOut = '0, gpHiDir = '0;
  logic [7:0]  padLoIn = '0;
  logic [7:0]  padLoOut, padLoOe, padHiOut, padHiOe;
  logic        ale, rdN, wrN;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  logic [7:0] sramMem [int];
  logic [7:0] refMem  [int];
  logic [7:0] latchLo = '0;

  always #4 clk = ~clk;

  xmem_bus_ctrl u0 (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWdata(cfgWdata), .cfgRdata(cfgRdata),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .stall(stall), .done(done), .rdData(rdData),
    .gpLoOut(gpLoOut), .gpLoDir(gpLoDir), .gpHiOut(gpHiOut), .gpHiDir(gpHiDir),
    .padLoIn(padLoIn), .padLoOut(padLoOut), .padLoOe(padLoOe),
    .padHiOut(padHiOut), .padHiOe(padHiOe), .ale(ale), .rdN(rdN), .wrN(wrN)
  );

  // SRAM with external address latch
  always @(negedge clk) begin
    int key;
    key = {padHiOut, latchLo};
    if (ale) latchLo <= padLoOut;
    if (!wrN) sramMem[key] = padLoOut;
    if (!rdN && sramMem.exists(key)) padLoIn <= sramMem[key];
    else padLoIn <= 8'h00;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired act=%0d exp=%0d", cyc, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [7:0] expRead(input logic [15:0] a);
    int k;
    k = a;
    return refMem.exists(k) ? refMem[k] : 8'h00;
  endfunction

  function automatic logic [7:0] expCfg(input bit en, input bit ws);
    return {en, ws, 6'b000000};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic setCfg(input bit en, input bit ws);
    @(negedge clk);
    cfgWe = 1'b1;
    cfgWdata = {en, ws, 6'b111111};
    @(negedge clk);
    cfgWe = 1'b0;
    // R1 written bits read back, low bits zero
    chk(cfgRdata == expCfg(en, ws), "R1", "cfg readback", cfgRdata, expCfg(en, ws));
  endtask

  task automatic access(input bit wr, input logic [15:0] a, input logic [7:0] d, input bit ws);
    string lenReq;
    int nStrb;
    lenReq = ws ? "R6" : "R5";
    nStrb = ws ? 3 : 2;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    #1;
    chk(stall == 1'b1, "R10", "stall at request", stall, 1);
    @(negedge clk);
    reqValid = 1'b0;
    reqAddr = $urandom; reqWdata = $urandom;
    chk(ale == 1'b1 && rdN && wrN, "R7", "addr cycle strobes", {ale, rdN, wrN}, 3'b111);
    chk(padLoOut == a[7:0] && padLoOe == 8'hFF, "R7", "low addr on shared pins",
        {padLoOe, padLoOut}, {8'hFF, a[7:0]});
    chk(padHiOut == a[15:8], "R7", "high addr", padHiOut, a[15:8]);
    for (int i = 0; i < nStrb; i++) begin
      @(negedge clk);
      chk(stall == 1'b1 && ale == 1'b0, "R10", "stall in strobe phase", {stall, ale}, 2'b10);
      chk(padHiOut == a[15:8], "R7", "high addr held", padHiOut, a[15:8]);
      if (wr) begin
        chk(!wrN && rdN, "R8", "write strobe", {rdN, wrN}, 2'b10);
        chk(padLoOut == d && padLoOe == 8'hFF, "R8", "write data driven",
            {padLoOe, padLoOut}, {8'hFF, d});
      end else begin
        chk(!rdN && wrN, "R9", "read strobe", {rdN, wrN}, 2'b01);
        chk(padLoOe == 8'h00, "R9", "shared pins released", padLoOe, 0);
      end
    end
    @(negedge clk);
    chk(rdN && wrN && !ale, lenReq, "strobes end on time", {ale, rdN, wrN}, 3'b011);
    chk(done == 1'b1 && stall == 1'b0, "R10", "done pulse, stall low", {done, stall}, 2'b10);
    if (wr) begin
      refMem[int'(a)] = d;
      chk(sramMem.exists(int'(a)) && sramMem[int'(a)] == d, "R8", "sram content",
          sramMem.exists(int'(a)) ? sramMem[int'(a)] : 8'hxx, d);
    end else begin
      chk(rdData == expRead(a), "R9", "read data", rdData, expRead(a));
    end
    @(negedge clk);
    chk(done == 1'b0, "R10", "done single cycle", done, 0);
  endtask

  task automatic noAccess(input logic [15:0] a, input string req);
    bit seen;
    seen = 1'b0;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = a; reqWdata = 8'h5A;
    #1;
    if (stall) seen = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    for (int i = 0; i < 5; i++) begin
      if (stall || done || ale || !rdN || !wrN) seen = 1'b1;
      @(negedge clk);
    end
    chk(!seen, req, "no external cycle", seen, 0);
  endtask

  logic [15:0] pool [16];

  initial begin
    void'($urandom(32'h1357));
    repeat (3) @(negedge clk);
    // R1 reset value
    chk(cfgRdata == 8'h00, "R1", "reset cfg", cfgRdata, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(cfgRdata == 8'h00 && !stall && !done, "R1", "cfg after reset", cfgRdata, 0);

    // R2 passthrough while disabled
    for (int i = 0; i < 6; i++) begin
      gpLoOut = $urandom; gpLoDir = $urandom; gpHiOut = $urandom; gpHiDir = $urandom;
      #1;
      chk(padLoOut == gpLoOut && padLoOe == gpLoDir, "R2", "low pins pass",
          {padLoOe, padLoOut}, {gpLoDir, gpLoOut});
      chk(padHiOut == gpHiOut && padHiOe == gpHiDir, "R2", "high pins pass",
          {padHiOe, padHiOut}, {gpHiDir, gpHiOut});
      @(negedge clk);
    end
    noAccess(16'hC123, "R2");

    // R1 wait-only, then bus enable
    setCfg(1'b0, 1'b1);
    setCfg(1'b1, 1'b0);
    // R3 ownership while idle
    gpLoDir = 8'hFF; gpHiDir = 8'h00;
    #1;
    chk(padHiOe == 8'hFF && padLoOe == 8'h00, "R3", "idle ownership",
        {padHiOe, padLoOe}, 16'hFF00);
    chk(!ale && rdN && wrN, "R3", "idle strobes", {ale, rdN, wrN}, 3'b011);

    // R4 internal range
    noAccess(16'(TOP), "R4");
    noAccess(16'h0000, "R4");

    // directed boundaries
    access(1'b1, 16'(TOP + 1), 8'hA5, 1'b0);
    access(1'b0, 16'(TOP + 1), 8'h00, 1'b0);
    access(1'b1, 16'hFFFF, 8'h3C, 1'b0);
    setCfg(1'b1, 1'b1);
    access(1'b0, 16'hFFFF, 8'h00, 1'b1);
    access(1'b1, 16'h8000, 8'hFF, 1'b1);
    access(1'b0, 16'h8000, 8'h00, 1'b1);

    // random mix
    for (int i = 0; i < 16; i++) pool[i] = 16'(TOP + 1 + ($urandom % (16'hFFFF - TOP)));
    for (int i = 0; i < 40; i++) begin
      bit ws;
      bit wr;
      logic [15:0] a;
      ws = $urandom % 2;
      wr = $urandom % 2;
      a = pool[$urandom % 16];
      setCfg(1'b1, ws);
      access(wr, a, 8'($urandom), ws);
    end

    // R2 back to passthrough
    setCfg(1'b0, 1'b0);
    gpLoOut = 8'h96; gpLoDir = 8'h0F; gpHiOut = 8'h69; gpHiDir = 8'hF0;
    #1;
    chk(padLoOut == 8'h96 && padLoOe == 8'h0F && padHiOut == 8'h69 && padHiOe == 8'hF0,
        "R2", "passthrough after disable", {padHiOe, padHiOut, padLoOe, padLoOut},
        32'hF0690F96);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule